// File: doc/BRIEF.md
# Register-Mapped Mesh Network Interface

This block connects a 32-bit processor register port to the local port of one mesh router. Software sets a destination tile once. Each write of a 16-bit payload then sends one whole packet into the network. The block fills in the source coordinates of its own tile from parameters. On the network side, each direction uses a four-phase request/acknowledge exchange, and each direction holds at most one packet.

Packets that arrive from the router are latched, acknowledged and held until software reads them. A status word shows whether the transmit side is still busy and whether a received packet is waiting. The processor port is a plain single-cycle select/write port. Read data is combinational and valid in the cycle the select is high.

Top module: `noc_reg_nic`

## Requirements
- R1: After reset, tx_req and rx_ack are low, and reads of Status (offset 0x0), Control (0x4) and Rx Data (0xC) return zero.
- R2: A write to Control (0x4) stores the destination column from bits [3:0] and the destination row from bits [7:4]. A read of Control returns these eight bits, and all higher bits read zero.
- R3: A write to Tx Data (0x8) while idle raises tx_req one cycle later. tx_pkt then carries destination column in [31:28], destination row in [27:24], source column in [23:20], source row in [19:16] and write-data bits [15:0] as payload.
- R4: tx_req and tx_pkt hold steady until tx_ack is seen high. tx_req falls in the cycle after tx_ack is first sampled high.
- R5: Status bit 0 (transmit busy) is set from the cycle after a Tx Data write until the cycle after tx_ack has been sampled low following the acknowledge.
- R6: A Tx Data write while transmit busy is set changes neither tx_pkt nor tx_req and starts no later transfer.
- R7: When rx_req is sampled high while no packet is waiting and rx_ack is low, rx_pkt is captured, and rx_ack and Status bit 1 (receive valid) rise one cycle later.
- R8: rx_ack falls in the cycle after rx_req is sampled low.
- R9: A read of Rx Data (0xC) returns the captured packet and clears receive valid from the next cycle on. Reading Status does not clear it.
- R10: While receive valid is set, a new rx_req is not acknowledged and the held packet is not overwritten. The new packet is accepted on the first clock edge after the clearing read.
- R11: Writes to Status (0x0) and Rx Data (0xC) have no effect on any register or on the network outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_wr is low |
| tx_req | output | 1 | Outgoing request |
| tx_pkt | output | 32 | Outgoing packet |
| tx_ack | input | 1 | Acknowledge from router |
| rx_req | input | 1 | Incoming request from router |
| rx_pkt | input | 32 | Incoming packet |
| rx_ack | output | 1 | Acknowledge to router |

## Verification
Each register write and each handshake edge takes effect at exactly one clock edge. tx_req, rx_ack and both status bits move one cycle after the input that causes them is sampled, and register reads return data within the same cycle. The bench drives inputs on the falling edge and samples outputs on the next falling edge, or several falling edges later for holds. Every expected value therefore lands exactly one register stage after its cause. Windows in which nothing may change, such as a request held without acknowledge or a blocked receive, are checked over several cycles before the releasing input is applied.

// File: rtl/noc_reg_nic.sv
module noc_reg_nic #(
  parameter int COORD_W = 4,
  parameter int PAY_W   = 16,
  parameter int BUS_W   = 32,
  parameter int MY_X    = 0,
  parameter int MY_Y    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             tx_req,
  output logic [BUS_W-1:0] tx_pkt,
  input  logic             tx_ack,
  input  logic             rx_req,
  input  logic [BUS_W-1:0] rx_pkt,
  output logic             rx_ack
);
  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_TX   = 4'h8;
  localparam logic [3:0] OFS_RX   = 4'hC;
  localparam int DEST_W = 2 * COORD_W;

  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_REL} tx_st_t;

  tx_st_t              tx_st;
  logic [DEST_W-1:0]   dest_q;
  logic [BUS_W-1:0]    txp_q;
  logic [BUS_W-1:0]    rxp_q;
  logic                rx_full;
  logic                rxa_q;

  wire wr_ctrl = bus_sel && bus_wr  && bus_addr == OFS_CTRL;
  wire wr_tx   = bus_sel && bus_wr  && bus_addr == OFS_TX;
  wire rd_rx   = bus_sel && !bus_wr && bus_addr == OFS_RX;
  wire tx_busy = tx_st != TX_IDLE;
  wire rx_take = rx_req && !rxa_q && !rx_full;

  wire [COORD_W-1:0] my_x = COORD_W'(MY_X);
  wire [COORD_W-1:0] my_y = COORD_W'(MY_Y);
  wire [BUS_W-1:0] new_pkt = {dest_q[COORD_W-1:0], dest_q[DEST_W-1:COORD_W],
                              my_x, my_y, bus_wdata[PAY_W-1:0]};

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:PAY_W];

  always_ff @(posedge clk) begin
    if (!rst_n) dest_q <= '0;
    else if (wr_ctrl) dest_q <= bus_wdata[DEST_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st <= TX_IDLE;
      txp_q <= '0;
    end else begin
      case (tx_st)
        TX_IDLE: if (wr_tx) begin
          txp_q <= new_pkt;
          tx_st <= TX_REQ;
        end
        TX_REQ:  if (tx_ack)  tx_st <= TX_REL;
        TX_REL:  if (!tx_ack) tx_st <= TX_IDLE;
        default: tx_st <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxa_q   <= 1'b0;
      rx_full <= 1'b0;
      rxp_q   <= '0;
    end else begin
      if (rx_take) begin
        rxp_q   <= rx_pkt;
        rxa_q   <= 1'b1;
        rx_full <= 1'b1;
      end else begin
        if (rxa_q && !rx_req) rxa_q <= 1'b0;
        if (rd_rx) rx_full <= 1'b0;
      end
    end
  end

  assign tx_req = tx_st == TX_REQ;
  assign tx_pkt = txp_q;
  assign rx_ack = rxa_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_STAT: bus_rdata = {{(BUS_W-2){1'b0}}, rx_full, tx_busy};
        OFS_CTRL: bus_rdata = {{(BUS_W-DEST_W){1'b0}}, dest_q};
        OFS_RX:   bus_rdata = rxp_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/noc_reg_nic_chk.sv
module noc_reg_nic_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_req,
  input logic [BUS_W-1:0] tx_pkt,
  input logic             tx_ack,
  input logic             rx_req,
  input logic             rx_ack
);
  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack |=> tx_req);

  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_req) |-> $past(tx_ack));

  // R4
  tx_pkt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack |=> $stable(tx_pkt));

  // R7
  rx_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack) |-> $past(rx_req));

  // R8
  rx_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack && rx_req |=> rx_ack);

  // R8
  rx_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack && !rx_req |=> !rx_ack);
endmodule

bind noc_reg_nic noc_reg_nic_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_pkt(tx_pkt),
  .tx_ack(tx_ack), .rx_req(rx_req), .rx_ack(rx_ack)
);

// File: tb/tb_noc_reg_nic.sv
module tb_noc_reg_nic;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_req, tx_ack = 1'b0;
  logic [31:0] tx_pkt;
  logic        rx_req = 1'b0, rx_ack;
  logic [31:0] rx_pkt = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  noc_reg_nic #(.MY_X(1), .MY_Y(2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_req(tx_req), .tx_pkt(tx_pkt), .tx_ack(tx_ack),
    .rx_req(rx_req), .rx_pkt(rx_pkt), .rx_ack(rx_ack));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 tx_req", {31'b0, tx_req}, 0);
    check("R1 rx_ack", {31'b0, rx_ack}, 0);
    rd(4'h0, d); check("R1 status", d, 0);
    rd(4'h4, d); check("R1 control", d, 0);
    rd(4'hC, d); check("R1 rxdata", d, 0);
  endtask

  task automatic t_control();
    logic [31:0] d;
    wr(4'h4, 32'hFFFF_FF53);
    rd(4'h4, d); check("R2 control readback", d, 32'h0000_0053);
  endtask

  task automatic t_transmit();
    logic [31:0] d;
    logic [31:0] exp_pkt = {4'h3, 4'h5, 4'h1, 4'h2, 16'hBEEF};
    wr(4'h8, 32'hAAAA_BEEF);
    check("R3 tx_req up", {31'b0, tx_req}, 1);
    check("R3 tx_pkt", tx_pkt, exp_pkt);
    rd(4'h0, d); check("R5 busy set", d & 32'h1, 1);
    wr(4'h8, 32'h0000_1111);
    check("R6 pkt kept in request", tx_pkt, exp_pkt);
    repeat (2) @(negedge clk);
    check("R4 req held", {31'b0, tx_req}, 1);
    check("R4 pkt held", tx_pkt, exp_pkt);
    tx_ack = 1;
    @(negedge clk);
    check("R4 req dropped", {31'b0, tx_req}, 0);
    rd(4'h0, d); check("R5 busy during release", d & 32'h1, 1);
    wr(4'h8, 32'h0000_2222);
    check("R6 pkt kept in release", tx_pkt, exp_pkt);
    check("R6 no req in release", {31'b0, tx_req}, 0);
    tx_ack = 0;
    @(negedge clk);
    rd(4'h0, d); check("R5 busy cleared", d & 32'h1, 0);
    check("R6 no late transfer", {31'b0, tx_req}, 0);
    wr(4'h4, 32'h0000_0097);
    wr(4'h8, 32'h0000_0042);
    check("R3 second pkt", tx_pkt, {4'h7, 4'h9, 4'h1, 4'h2, 16'h0042});
    @(negedge clk); tx_ack = 1;
    @(negedge clk); tx_ack = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_receive();
    logic [31:0] d;
    @(negedge clk);
    rx_pkt = 32'hCAFE_0001; rx_req = 1;
    @(negedge clk);
    check("R7 ack up", {31'b0, rx_ack}, 1);
    rd(4'h0, d); check("R7 rx valid", d & 32'h2, 2);
    rd(4'h0, d); check("R9 status read keeps valid", d & 32'h2, 2);
    rx_req = 0;
    @(negedge clk);
    check("R8 ack down", {31'b0, rx_ack}, 0);
    rx_pkt = 32'hD00D_0002; rx_req = 1;
    repeat (3) @(negedge clk);
    check("R10 blocked ack", {31'b0, rx_ack}, 0);
    rd(4'hC, d); check("R9 rx data", d, 32'hCAFE_0001);
    check("R10 not yet taken", {31'b0, rx_ack}, 0);
    @(negedge clk);
    check("R10 taken after read", {31'b0, rx_ack}, 1);
    rx_req = 0;
    rd(4'hC, d); check("R10 new data", d, 32'hD00D_0002);
    rd(4'h0, d); check("R9 valid cleared", d & 32'h2, 0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    @(negedge clk);
    rx_pkt = 32'h1234_5678; rx_req = 1;
    @(negedge clk); rx_req = 0;
    @(negedge clk);
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'hC, 32'h0BAD_0BAD);
    check("R11 no tx", {31'b0, tx_req}, 0);
    check("R11 rx_ack", {31'b0, rx_ack}, 0);
    rd(4'h0, d); check("R11 status", d, 32'h2);
    rd(4'h4, d); check("R11 control", d, 32'h97);
    rd(4'hC, d); check("R11 rxdata", d, 32'h1234_5678);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_control();
    t_transmit();
    t_receive();
    t_ignored();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule